// File: doc/BRIEF.md
# Clock-Synchronous Serial Master

This block is a master-side serial shifter for byte transfers. The CPU drives it through four 16-bit registers on a simple read/write strobe bus. The block generates a serial clock, drives a data-out line and samples a data-in line. It has two enables, transmit and receive. Together they select one of three modes: transmit-only, receive-only or full-duplex.

Register accesses decide when a transfer begins. In transmit and full-duplex modes, writing transmit data starts a frame. In receive-only mode, turning the receive enable on starts the first frame, and each read of the received byte starts the next one while the enable stays on. Three status flags report the outcome: transmit end, receive full and overrun. An overrun halts all traffic until software acknowledges it.

Register map (the offset is `bus_addr`):
- Offset 0, control: bit 15 is the transmit enable, bit 14 is the receive enable, and bits 6:0 hold the half-period field H.
- Offset 1, status: bit 2 is transmit end, bit 1 is receive full, bit 0 is overrun.
- Offset 2: transmit data, bits 7:0.
- Offset 3: receive data, bits 7:0.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, control and status read as 0, `sclk` is 1 and `sdo` is 1.
- R2: With both enables set, a write to offset 2 starts one frame of 8 bits, MSB first. `sdo` changes when `sclk` falls and `sdi` is sampled when `sclk` rises. After the frame, the shifted-in byte is readable at offset 3, and receive full (status bit 1) is set.
- R3: `sclk` idles high. During a frame its period is 2·H' system clocks, where H' = 128 for H = 0, H' = 2 for H = 1, and H' = H otherwise. This gives even divisors from 4 to 256.
- R4: A control write that moves the enables from one nonzero combination to a different nonzero combination leaves both enables unchanged. Changes from or to 00 take effect.
- R5: Transmit end (status bit 2) sets when a transmitting frame finishes and no further transmit data is waiting. An accepted write to offset 2 clears it. Data written during a frame is sent as the next frame, with no gap.
- R6: Reading offset 3 clears receive full.
- R7: When a frame that receives completes while receive full is 1, overrun (status bit 0) sets, the new byte is discarded and offset 3 keeps the old byte.
- R8: While overrun is 1, no frame starts, even with transmit data waiting. Waiting data is sent once overrun clears.
- R9: Writing 0 to status bit 0 clears overrun only if status has been read with overrun at 1 since it set. Writing 1 to any status bit has no effect. Writing 0 to bit 2 or bit 1 clears that flag.
- R10: In receive-only mode, `sdo` stays 1. Reading offset 3 while the receive enable is 1 starts the next reception. Reading it after the receive enable is cleared starts nothing.
- R11: Setting the receive enable from 00 to receive-only while any status flag is 1 starts no frame.
- R12: A write to offset 2 while the transmit enable is 0 is ignored: offset 2 keeps its old value and no frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| sclk | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Full-duplex frames are run with random transmit and receive bytes and random small dividers. Any bit-order, sampling-edge or divider-decode fault therefore shows up as a byte or period mismatch in one of the two directions. Directed sequences cover the remaining cases. Two back-to-back writes check that waiting data follows without a gap and that the second reception overruns. Status writes made before and after a status read show whether the acknowledge rule for overrun is enforced. Receive-only runs compare a read made with the enable on against one made with it off, which shows whether continuation depends on the enable.

// File: rtl/sync_serial_master.sv
`timescale 1ns/1ps
module sync_serial_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  input  logic        sdi,
  output logic        sdo
);
  logic       te, re;
  logic [6:0] hfield;
  logic [7:0] tdr, rdr, sh;
  logic       pend, busy, tx_act, rx_act, sclk_q, sdo_q;
  logic       tend, rdrf, orer, orer_seen, rx_req;
  logic [2:0] bits;
  logic [7:0] cnt, half;

  wire [1:0] en     = {te, re};
  wire [1:0] new_en = bus_wdata[15:14];
  wire w_ctrl = bus_wr && bus_addr == 2'd0;
  wire w_stat = bus_wr && bus_addr == 2'd1;
  wire w_tdr  = bus_wr && bus_addr == 2'd2;
  wire r_stat = bus_rd && bus_addr == 2'd1;
  wire r_rdr  = bus_rd && bus_addr == 2'd3;
  wire mode_ok = (en == 2'b00) || (new_en == 2'b00) || (new_en == en);
  wire tdr_ok  = w_tdr && te;
  wire flags_clr = !tend && !rdrf && !orer;
  wire rx_on_req = w_ctrl && en == 2'b00 && new_en == 2'b01 && flags_clr;

  assign half = (hfield == 7'd0) ? 8'd128 : (hfield == 7'd1) ? 8'd2 : {1'b0, hfield};

  wire start_tx = !busy && pend && te && !orer;
  wire start_rx = !busy && !start_tx && rx_req && re && !te && !orer;
  wire tick     = busy && cnt == half - 8'd1;
  wire done     = tick && !sclk_q && bits == 3'd7;
  wire [7:0] rx_byte = {sh[6:0], sdi};

  assign sclk = sclk_q;
  assign sdo  = sdo_q;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {te, re, 7'd0, hfield};
      2'd1:    bus_rdata = {13'd0, tend, rdrf, orer};
      2'd2:    bus_rdata = {8'd0, tdr};
      default: bus_rdata = {8'd0, rdr};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te <= 1'b0; re <= 1'b0; hfield <= 7'd0;
    end else if (w_ctrl) begin
      hfield <= bus_wdata[6:0];
      if (mode_ok) {te, re} <= new_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr <= 8'd0; pend <= 1'b0;
    end else begin
      if (tdr_ok) tdr <= bus_wdata[7:0];
      if (tdr_ok) pend <= 1'b1;
      else if (start_tx || !te) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_req <= 1'b0;
    else if (start_rx) rx_req <= 1'b0;
    else if (rx_on_req) rx_req <= 1'b1;
    else if (r_rdr && re && !te) rx_req <= 1'b1;
    else if (!re || te) rx_req <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= 8'd0; bits <= 3'd0; sh <= 8'd0;
      sclk_q <= 1'b1; sdo_q <= 1'b1; tx_act <= 1'b0; rx_act <= 1'b0;
    end else if (start_tx || start_rx) begin
      busy <= 1'b1; cnt <= 8'd0; bits <= 3'd0; sclk_q <= 1'b1;
      sh <= start_tx ? tdr : 8'hFF;
      tx_act <= start_tx;
      rx_act <= start_tx ? re : 1'b1;
    end else if (busy) begin
      if (tick) begin
        cnt <= 8'd0;
        if (sclk_q) begin
          sclk_q <= 1'b0;
          sdo_q  <= tx_act ? sh[7] : 1'b1;
        end else begin
          sclk_q <= 1'b1;
          sh     <= rx_byte;
          bits   <= bits + 3'd1;
          if (bits == 3'd7) busy <= 1'b0;
        end
      end else begin
        cnt <= cnt + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend <= 1'b0; rdrf <= 1'b0; orer <= 1'b0; orer_seen <= 1'b0; rdr <= 8'd0;
    end else begin
      if (tdr_ok) tend <= 1'b0;
      else if (done && tx_act && !pend) tend <= 1'b1;
      else if (w_stat && !bus_wdata[2]) tend <= 1'b0;

      if (done && rx_act && !rdrf) begin
        rdrf <= 1'b1;
        rdr  <= rx_byte;
      end else if (r_rdr || (w_stat && !bus_wdata[1])) rdrf <= 1'b0;

      if (done && rx_act && rdrf) orer <= 1'b1;
      else if (w_stat && !bus_wdata[0] && orer_seen) orer <= 1'b0;

      if (!orer) orer_seen <= 1'b0;
      else if (r_stat) orer_seen <= 1'b1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_q); // R3
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && !mode_ok) |=> en == $past(en)); // R4
  AST_TEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tdr_ok |=> !tend); // R5
  AST_RDRF_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rdr && !done) |=> !rdrf); // R6
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(orer) |-> $stable(rdr)); // R7
  AST_OVERRUN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (orer && !busy) |=> !busy); // R8
endmodule

// File: tb/sync_serial_master_tb.sv
`timescale 1ns/1ps
module sync_serial_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'd0, bus_rdata;
  logic sclk, sdo, sdi;
  int tests = 0, fails = 0;
  logic [15:0] slv = 16'd0, mon = 16'd0;
  int edges = 0;
  time last_rise = 0, period = 0;

  always #10 clk = ~clk;

  sync_serial_master dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .sdi(sdi), .sdo(sdo));

  initial begin
    sdi = 1'b1;
    forever begin
      @(negedge sclk);
      sdi = slv[15];
      slv = {slv[14:0], 1'b0};
    end
  end

  initial begin
    forever begin
      @(posedge sclk);
      mon = {mon[14:0], sdo};
      edges = edges + 1;
      if (last_rise != 0) period = $time - last_rise;
      last_rise = $time;
    end
  end

  function automatic int exp_half(input int h);
    if (h == 0) return 128;
    if (h == 1) return 2;
    return h;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic arm(input logic [7:0] rxb);
    slv = {rxb, 8'h00}; mon = 16'd0; edges = 0; last_rise = 0; period = 0;
  endtask

  task automatic wait_frames(input int n, input int h);
    repeat (n * 16 * h + 12) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0] a, b, c, e, f, g;
    int h;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    rd(2'd0, d); chk("R1 ctrl", d, 16'd0);
    rd(2'd1, d); chk("R1 status", d, 16'd0);
    chk("R1 sclk", {15'd0, sclk}, 16'd1);
    chk("R1 sdo", {15'd0, sdo}, 16'd1);

    for (int i = 0; i < 20; i++) begin
      h = (i == 0) ? 0 : (i == 1) ? 1 : 2 + ($urandom % 14);
      wr(2'd0, 16'hC000 | 16'(h));
      a = 8'($urandom); b = 8'($urandom);
      arm(b);
      wr(2'd2, {8'd0, a});
      wait_frames(1, exp_half(h));
      chk("R2 tx byte", mon & 16'h00FF, {8'd0, a});
      chk("R2 edges", 16'(edges), 16'd8);
      chk("R3 period", 16'(period), 16'(40 * exp_half(h)));
      chk("R3 idle", {15'd0, sclk}, 16'd1);
      rd(2'd1, d); chk("R5 R2 status", d, 16'h0006);
      rd(2'd3, d); chk("R2 rx byte", d, {8'd0, b});
      rd(2'd1, d); chk("R6 rdrf cleared", d, 16'h0004);
    end

    wr(2'd0, 16'hC002);
    a = 8'h5A; c = 8'hC3; b = 8'h81; e = 8'h3C;
    slv = {b, 8'h7E}; mon = 16'd0; edges = 0;
    wr(2'd2, {8'd0, a});
    wr(2'd2, {8'd0, c});
    wait_frames(2, 2);
    chk("R5 back to back", mon, {a, c});
    chk("R5 edges", 16'(edges), 16'd16);
    wr(2'd1, 16'h0006);
    rd(2'd1, d); chk("R9 R7 overrun held", d, 16'h0007);
    arm(8'h99);
    wr(2'd2, {8'd0, e});
    wait_frames(1, 2);
    chk("R8 frozen", 16'(edges), 16'd0);
    rd(2'd1, d); chk("R8 tend cleared", d, 16'h0003);
    rd(2'd3, d); chk("R7 old byte kept", d, {8'd0, b});
    wr(2'd1, 16'h0007);
    rd(2'd1, d); chk("R9 write one", d, 16'h0001);
    arm(8'h99);
    wr(2'd1, 16'h0006);
    wait_frames(1, 2);
    chk("R8 resume", mon & 16'h00FF, {8'd0, e});
    rd(2'd3, d); chk("R8 resume rx", d, 16'h0099);

    wr(2'd0, 16'h0002);
    arm(8'h00);
    wr(2'd2, 16'h00AA);
    wait_frames(1, 2);
    rd(2'd2, d); chk("R12 tdr kept", d, {8'd0, e});
    chk("R12 no frame", 16'(edges), 16'd0);

    wr(2'd0, 16'h8002);
    wr(2'd0, 16'hC002);
    rd(2'd0, d); chk("R4 to duplex ignored", d, 16'h8002);
    wr(2'd0, 16'h4002);
    rd(2'd0, d); chk("R4 swap ignored", d, 16'h8002);
    wr(2'd0, 16'h0002);
    wr(2'd0, 16'hC002);
    rd(2'd0, d); chk("R4 via idle", d, 16'hC002);
    wr(2'd0, 16'h0002);

    arm(8'h00);
    wr(2'd0, 16'h4002);
    wait_frames(1, 2);
    chk("R11 no start with flag", 16'(edges), 16'd0);
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'h0003);
    rd(2'd1, d); chk("R9 R1 flags clear", d, 16'h0000);
    f = 8'hB4; g = 8'h2D;
    arm(f);
    wr(2'd0, 16'h4003);
    wait_frames(1, 3);
    chk("R10 sdo high", mon & 16'h00FF, 16'h00FF);
    chk("R10 first rx edges", 16'(edges), 16'd8);
    arm(g);
    rd(2'd3, d); chk("R10 first byte", d, {8'd0, f});
    wait_frames(1, 3);
    chk("R10 continued", 16'(edges), 16'd8);
    wr(2'd0, 16'h0003);
    arm(8'h00);
    rd(2'd3, d); chk("R10 second byte", d, {8'd0, g});
    wait_frames(1, 3);
    chk("R10 stopped", 16'(edges), 16'd0);
    rd(2'd1, d); chk("R6 rdrf after read", d, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule